// File: doc/BRIEF.md
# Watchdog Timer with Pretimeout

This peripheral guards a system against software hangs. It sits on a simple register bus (address, write strobe, write data, combinational read data) and holds two down-counters: a main watchdog counter and a second counter that serves as an early warning. Software loads both counters and then keeps rewriting them. If it stops doing so, the warning counter runs out first and raises a pretimeout interrupt. The main counter runs out later and raises a timeout interrupt. It can also request a system reset.

Each counter takes its ticks from one of two sources. The first is a shared power-of-two prescaler driven by the bus clock, whose ratio is a field in the control register. The second is an external fixed-reference tick strobe, chosen for each counter by its own control bit. The reset request passes through a gate with three conditions: a reset-enable register, a reset-mask register (masked after reset) and the watchdog's own run bit. The request is raised only when all three allow it. Sticky status flags record each expiry until software clears them by writing zero.

Register offsets: control 0x00, status 0x04, warning counter 0x1C, watchdog counter 0x34, reset enable 0x40, reset mask 0x44.

Top module: `wdt_pretimer`

## Requirements
- R1: After reset the registers read as follows. Control reads 0 and status reads 0. Both counters read 0xFFFFFFFF. Reset enable (0x40) reads 0 and reset mask (0x44) reads 0x400. pre_irq, wd_irq and sys_rst_req are low.
- R2: A write to 0x34 loads the watchdog counter and a write to 0x1C loads the warning counter. Reading either offset returns the live remaining count.
- R3: While control bit 8 is 1, the watchdog counter decrements by one per tick. While control bit 8 is 0 it holds its value. It never increases except by a load.
- R4: Control bits [18:16] hold a ratio n, and the prescaler tick then occurs once every 2^n clock cycles. When control bit 10 is 1, the watchdog counts ref_tick pulses instead of prescaler ticks. When control bit 12 is 1, the warning counter does the same.
- R5: The watchdog counter can step from 1 to 0. In that clock edge, status bit 31 sets and wd_irq goes high for exactly one cycle. The counter then stays at 0 until it is reloaded.
- R6: The warning counter decrements per tick while control bit 2 is 1. When it steps from 1 to 0, status bit 8 sets and pre_irq pulses for one cycle, and the counter holds at 0 until reloaded.
- R7: A write to status (0x04) clears each flag whose bit (31 or 8) is written 0. A flag whose bit is written 1 is left unchanged.
- R8: sys_rst_req goes high one cycle after four conditions all hold: reset-enable bit 8 is 1, reset-mask bit 10 is 0, control bit 8 is 1, and status bit 31 is set. It falls one cycle after any of these conditions ends.
- R9: Reads of unmapped offsets return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One-cycle strobe from the fixed reference clock domain |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pre_irq | output | 1 | One-cycle pulse when the warning counter expires |
| wd_irq | output | 1 | One-cycle pulse when the watchdog counter expires |
| sys_rst_req | output | 1 | Registered, gated system reset request level |

## Verification
The bench builds the block with its defaults: CNT_W of 32, RATIO_W of 3 and ADDR_W of 8. At these values the full-width reset count of 0xFFFFFFFF can be read back directly, and every prescaler ratio up to divide-by-128 is reachable. The bench loads small counts, so expiry, the single-cycle interrupts, and each gate input of the reset request all happen within a few cycles. It measures ratios 3 and 5 over whole prescaler periods, so the number of ticks in a window is exact whatever the prescaler phase is.

// File: rtl/wdt_pretimer.sv
module wdt_pretimer #(
  parameter int CNT_W   = 32,
  parameter int ADDR_W  = 8,
  parameter int RATIO_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              pre_irq,
  output logic              wd_irq,
  output logic              sys_rst_req
);

  localparam int PS_W      = (1 << RATIO_W) - 1;
  localparam int RATIO_LSB = 16;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [31:0] CTRL_MASK =
    32'h0000_1504 | (((32'd1 << RATIO_W) - 32'd1) << RATIO_LSB);

  localparam logic [ADDR_W-1:0] OFS_CTRL  = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] OFS_STAT  = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] OFS_PRE   = ADDR_W'('h1C);
  localparam logic [ADDR_W-1:0] OFS_WD    = ADDR_W'('h34);
  localparam logic [ADDR_W-1:0] OFS_RSTEN = ADDR_W'('h40);
  localparam logic [ADDR_W-1:0] OFS_RMASK = ADDR_W'('h44);

  logic [31:0]        ctrl_q;
  logic [CNT_W-1:0]   wd_cnt, pre_cnt;
  logic [PS_W-1:0]    ps_cnt;
  logic               wd_flag, pre_flag, rst_en_q, mask_q;

  wire wr_ctrl  = bus_we && (bus_addr == OFS_CTRL);
  wire wr_stat  = bus_we && (bus_addr == OFS_STAT);
  wire wr_pre   = bus_we && (bus_addr == OFS_PRE);
  wire wr_wd    = bus_we && (bus_addr == OFS_WD);
  wire wr_rsten = bus_we && (bus_addr == OFS_RSTEN);
  wire wr_rmask = bus_we && (bus_addr == OFS_RMASK);

  wire wd_run    = ctrl_q[8];
  wire pre_run   = ctrl_q[2];
  wire wd_fixed  = ctrl_q[10];
  wire pre_fixed = ctrl_q[12];
  wire [RATIO_W-1:0] ratio = ctrl_q[RATIO_LSB +: RATIO_W];

  wire [PS_W-1:0] ps_mask = ~({PS_W{1'b1}} << ratio);
  wire ps_tick  = &(ps_cnt | ~ps_mask);
  wire wd_tick  = wd_fixed  ? ref_tick : ps_tick;
  wire pre_tick = pre_fixed ? ref_tick : ps_tick;

  wire wd_step  = wd_run  && wd_tick  && (wd_cnt  != '0) && !wr_wd;
  wire pre_step = pre_run && pre_tick && (pre_cnt != '0) && !wr_pre;
  wire wd_hit   = wd_step  && (wd_cnt  == CNT_ONE);
  wire pre_hit  = pre_step && (pre_cnt == CNT_ONE);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= bus_wdata & CTRL_MASK;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ps_cnt <= '0;
    else        ps_cnt <= ps_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       wd_cnt <= CNT_MAX;
    else if (wr_wd)   wd_cnt <= bus_wdata[CNT_W-1:0];
    else if (wd_step) wd_cnt <= wd_cnt - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        pre_cnt <= CNT_MAX;
    else if (wr_pre)   pre_cnt <= bus_wdata[CNT_W-1:0];
    else if (pre_step) pre_cnt <= pre_cnt - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wd_flag  <= 1'b0;
      pre_flag <= 1'b0;
      wd_irq   <= 1'b0;
      pre_irq  <= 1'b0;
    end else begin
      wd_flag  <= wd_hit  | (wd_flag  & ~(wr_stat & ~bus_wdata[31]));
      pre_flag <= pre_hit | (pre_flag & ~(wr_stat & ~bus_wdata[8]));
      wd_irq   <= wd_hit;
      pre_irq  <= pre_hit;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rst_en_q <= 1'b0;
      mask_q   <= 1'b1;
    end else begin
      if (wr_rsten) rst_en_q <= bus_wdata[8];
      if (wr_rmask) mask_q   <= bus_wdata[10];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sys_rst_req <= 1'b0;
    else        sys_rst_req <= rst_en_q && !mask_q && wd_run && wd_flag;

  always_comb begin
    case (bus_addr)
      OFS_CTRL:  bus_rdata = ctrl_q;
      OFS_STAT:  bus_rdata = {wd_flag, 22'd0, pre_flag, 8'd0};
      OFS_PRE:   bus_rdata = 32'(pre_cnt);
      OFS_WD:    bus_rdata = 32'(wd_cnt);
      OFS_RSTEN: bus_rdata = {23'd0, rst_en_q, 8'd0};
      OFS_RMASK: bus_rdata = {21'd0, mask_q, 10'd0};
      default:   bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/wdt_pretimer_chk.sv
module wdt_pretimer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wd_irq,
  input logic             pre_irq,
  input logic             wd_flag,
  input logic             pre_flag,
  input logic             sys_rst_req,
  input logic             rst_en_q,
  input logic             mask_q,
  input logic             wd_run,
  input logic [CNT_W-1:0] wd_cnt,
  input logic [CNT_W-1:0] pre_cnt,
  input logic             wr_wd,
  input logic             wr_pre
);

  assert_wd_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wd_irq |=> !wd_irq);

  assert_wd_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wd_irq |-> wd_flag);

  assert_wd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_cnt == '0 && !wr_wd) |=> (wd_cnt == '0));

  assert_wd_no_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_wd |=> (wd_cnt <= $past(wd_cnt)));

  assert_pre_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pre_irq |=> !pre_irq);

  assert_pre_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pre_irq |-> pre_flag);

  assert_pre_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_cnt == '0 && !wr_pre) |=> (pre_cnt == '0));

  assert_rst_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> $past(rst_en_q && !mask_q && wd_run && wd_flag));

endmodule

bind wdt_pretimer wdt_pretimer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wd_irq(wd_irq), .pre_irq(pre_irq),
  .wd_flag(wd_flag), .pre_flag(pre_flag), .sys_rst_req(sys_rst_req),
  .rst_en_q(rst_en_q), .mask_q(mask_q), .wd_run(wd_run),
  .wd_cnt(wd_cnt), .pre_cnt(pre_cnt), .wr_wd(wr_wd), .wr_pre(wr_pre)
);

// File: tb/sim_wdt_pretimer.sv
module sim_wdt_pretimer;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_CTRL = 8'h00, A_STAT = 8'h04, A_PRE = 8'h1C,
                         A_WD = 8'h34, A_RSTEN = 8'h40, A_RMASK = 8'h44;

  logic clk = 1'b0, rst_n = 1'b0, ref_tick = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic pre_irq, wd_irq, sys_rst_req;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_pretimer u0 (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_addr(addr),
    .bus_we(we), .bus_wdata(wdata), .bus_rdata(rdata),
    .pre_irq(pre_irq), .wd_irq(wd_irq), .sys_rst_req(sys_rst_req)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_CTRL, v);  chk("R1 ctrl", v, 32'h0);
    rd(A_STAT, v);  chk("R1 status", v, 32'h0);
    rd(A_WD, v);    chk("R1 wd count", v, 32'hFFFF_FFFF);
    rd(A_PRE, v);   chk("R1 pre count", v, 32'hFFFF_FFFF);
    rd(A_RSTEN, v); chk("R1 reset enable", v, 32'h0);
    rd(A_RMASK, v); chk("R1 reset mask", v, 32'h400);
    chk("R1 outputs", {29'd0, pre_irq, wd_irq, sys_rst_req}, 32'h0);
  endtask

  task automatic t_load();
    logic [31:0] v;
    wr(A_WD, 32'h1234_5678);
    rd(A_WD, v);  chk("R2 wd load", v, 32'h1234_5678);
    wr(A_PRE, 32'h0000_00A5);
    rd(A_PRE, v); chk("R2 pre load", v, 32'h0000_00A5);
    repeat (4) @(negedge clk);
    rd(A_WD, v);  chk("R3 disabled wd holds", v, 32'h1234_5678);
  endtask

  task automatic t_decrement();
    logic [31:0] v;
    wr(A_WD, 32'd10);
    wr(A_CTRL, 32'h100);
    rd(A_WD, v); chk("R3 start value", v, 32'd10);
    repeat (4) @(negedge clk);
    rd(A_WD, v); chk("R3 four ticks", v, 32'd6);
    wr(A_CTRL, 32'h0);
    rd(A_WD, v); chk("R3 stop value", v, 32'd4);
    repeat (5) @(negedge clk);
    rd(A_WD, v); chk("R3 held after disable", v, 32'd4);
  endtask

  task automatic t_prescale();
    logic [31:0] v;
    wr(A_CTRL, 32'h0);
    wr(A_WD, 32'd1000);
    wr(A_CTRL, 32'h100 | (32'd3 << 16));
    repeat (64) @(negedge clk);
    rd(A_WD, v); chk("R4 ratio 3 over 64 cycles", v, 32'd992);
    wr(A_CTRL, 32'h0);
    wr(A_WD, 32'd1000);
    wr(A_CTRL, 32'h100 | (32'd5 << 16));
    repeat (128) @(negedge clk);
    rd(A_WD, v); chk("R4 ratio 5 over 128 cycles", v, 32'd996);
  endtask

  task automatic t_fixed();
    logic [31:0] v;
    wr(A_CTRL, 32'h0);
    wr(A_WD, 32'd50);
    wr(A_CTRL, 32'h500);
    repeat (10) @(negedge clk);
    rd(A_WD, v); chk("R4 fixed wd idle without ref", v, 32'd50);
    ref_tick = 1'b1;
    repeat (3) @(negedge clk);
    ref_tick = 1'b0;
    rd(A_WD, v); chk("R4 fixed wd counts ref ticks", v, 32'd47);
    wr(A_CTRL, 32'h0);
    wr(A_PRE, 32'd20);
    wr(A_CTRL, 32'h1004);
    repeat (10) @(negedge clk);
    rd(A_PRE, v); chk("R4 fixed pre idle without ref", v, 32'd20);
    ref_tick = 1'b1;
    repeat (2) @(negedge clk);
    ref_tick = 1'b0;
    rd(A_PRE, v); chk("R4 fixed pre counts ref ticks", v, 32'd18);
  endtask

  task automatic t_wd_expire();
    logic [31:0] v;
    wr(A_CTRL, 32'h0);
    wr(A_STAT, 32'h0);
    wr(A_WD, 32'd3);
    wr(A_CTRL, 32'h100);
    @(negedge clk);
    @(negedge clk);
    rd(A_WD, v); chk("R5 one before zero", v, 32'd1);
    chk("R5 no early irq", {31'd0, wd_irq}, 32'd0);
    @(negedge clk);
    rd(A_WD, v); chk("R5 reached zero", v, 32'd0);
    chk("R5 irq high", {31'd0, wd_irq}, 32'd1);
    rd(A_STAT, v); chk("R5 expired flag", v, 32'h8000_0000);
    @(negedge clk);
    chk("R5 irq one cycle", {31'd0, wd_irq}, 32'd0);
    repeat (5) @(negedge clk);
    rd(A_WD, v); chk("R5 holds at zero", v, 32'd0);
    rd(A_STAT, v); chk("R5 flag sticky", v, 32'h8000_0000);
  endtask

  task automatic t_pre_expire();
    logic [31:0] v;
    wr(A_CTRL, 32'h0);
    wr(A_STAT, 32'h0);
    wr(A_PRE, 32'd2);
    wr(A_CTRL, 32'h4);
    @(negedge clk);
    chk("R6 no early irq", {31'd0, pre_irq}, 32'd0);
    @(negedge clk);
    rd(A_PRE, v); chk("R6 reached zero", v, 32'd0);
    chk("R6 irq high", {31'd0, pre_irq}, 32'd1);
    rd(A_STAT, v); chk("R6 pre flag only", v, 32'h0000_0100);
    @(negedge clk);
    chk("R6 irq one cycle", {31'd0, pre_irq}, 32'd0);
    repeat (3) @(negedge clk);
    rd(A_PRE, v); chk("R6 holds at zero", v, 32'd0);
  endtask

  task automatic t_status();
    logic [31:0] v;
    wr(A_CTRL, 32'h0);
    wr(A_WD, 32'd2);
    wr(A_PRE, 32'd2);
    wr(A_CTRL, 32'h104);
    repeat (4) @(negedge clk);
    rd(A_STAT, v); chk("R7 both flags set", v, 32'h8000_0100);
    wr(A_STAT, 32'h8000_0000);
    rd(A_STAT, v); chk("R7 write 0 clears bit 8 only", v, 32'h8000_0000);
    wr(A_STAT, 32'h0000_0100);
    rd(A_STAT, v); chk("R7 write 0 clears bit 31", v, 32'h0);
  endtask

  task automatic t_reset_out();
    wr(A_CTRL, 32'h0);
    wr(A_STAT, 32'h0);
    wr(A_RSTEN, 32'h100);
    wr(A_WD, 32'd2);
    wr(A_CTRL, 32'h100);
    repeat (4) @(negedge clk);
    chk("R8 masked, no request", {31'd0, sys_rst_req}, 32'd0);
    wr(A_RMASK, 32'h0);
    chk("R8 request one cycle late", {31'd0, sys_rst_req}, 32'd0);
    @(negedge clk);
    chk("R8 request on unmask", {31'd0, sys_rst_req}, 32'd1);
    wr(A_STAT, 32'h0);
    chk("R8 request held one cycle", {31'd0, sys_rst_req}, 32'd1);
    @(negedge clk);
    chk("R8 drop on flag clear", {31'd0, sys_rst_req}, 32'd0);
    wr(A_WD, 32'd1);
    repeat (3) @(negedge clk);
    chk("R8 request after expiry", {31'd0, sys_rst_req}, 32'd1);
    wr(A_CTRL, 32'h0);
    @(negedge clk);
    chk("R8 drop on disable", {31'd0, sys_rst_req}, 32'd0);
    wr(A_CTRL, 32'h100);
    repeat (2) @(negedge clk);
    chk("R8 request on re-enable", {31'd0, sys_rst_req}, 32'd1);
    wr(A_RSTEN, 32'h0);
    @(negedge clk);
    chk("R8 drop on enable clear", {31'd0, sys_rst_req}, 32'd0);
  endtask

  task automatic t_unmapped();
    logic [31:0] c0, s0, w0, p0, v;
    rd(A_CTRL, c0); rd(A_STAT, s0); rd(A_WD, w0); rd(A_PRE, p0);
    wr(8'h20, 32'hDEAD_BEEF);
    wr(8'h38, 32'hFFFF_FFFF);
    rd(8'h20, v); chk("R9 unmapped 0x20 reads 0", v, 32'h0);
    rd(8'h08, v); chk("R9 unmapped 0x08 reads 0", v, 32'h0);
    rd(A_CTRL, v); chk("R9 ctrl untouched", v, c0);
    rd(A_STAT, v); chk("R9 status untouched", v, s0);
    rd(A_WD, v);   chk("R9 wd untouched", v, w0);
    rd(A_PRE, v);  chk("R9 pre untouched", v, p0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_load();
    t_decrement();
    t_prescale();
    t_fixed();
    t_wd_expire();
    t_pre_expire();
    t_status();
    t_reset_out();
    t_unmapped();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule